// File: doc/BRIEF.md
# Link Reset Retry Controller

This block supervises a high-speed serial link through two status inputs: one that reports the link as up, and one that reports the receive lanes as aligned. When asked to check the link, the controller samples both inputs once. If both are high, it reports the link as good right away. If either is low, it enters a recovery sequence. In that sequence it pulses a link-reset output, lets the link settle for a programmable number of microsecond ticks, and samples the inputs again. It keeps settling and sampling, and from time to time issues a new reset pulse, until the link looks healthy or a budget runs out.

Two budgets bound the recovery. An attempt budget limits how many reset pulses one check may issue. Within each attempt, a per-attempt limit caps the number of settle-and-sample rounds. Over all of this sits a sample budget that is shared by every attempt of the check. It is loaded once per check and never reloaded, so a late attempt may be cut short when the sample budget runs out. When the sequence ends, the controller raises a one-cycle done pulse. The link-good result stays valid on its output until the next check finishes.

The controller is a six-state machine:
- ST_IDLE goes to ST_CHECK on a start request.
- ST_CHECK goes to ST_DONE if the link is healthy, otherwise to ST_PULSE.
- ST_PULSE always goes to ST_SETTLE.
- ST_SETTLE goes to ST_SAMPLE when the settle time has elapsed.
- ST_SAMPLE goes to one of three states:
  - ST_DONE when the link is healthy, when the sample budget is spent, or when the attempt ends with no reset pulses left;
  - ST_PULSE when the attempt ends and reset pulses remain;
  - ST_SETTLE otherwise.
- ST_DONE always goes to ST_IDLE.

Settle time is measured with a prescaled tick that restarts each time the machine enters ST_SETTLE, so every settle window has the same length.

Top module: `link_retry_ctrl`

## Requirements
- R1: If both link_up_i and lane_align_i are 1 in the cycle after start is accepted (the check cycle), done_o rises in the next cycle with link_ok_o = 1, and link_rst_o is never asserted.
- R2: If the link is up but not aligned at the check, link_rst_o is pulsed in the cycle after the check, and the result is not reported as good at that point.
- R3: If link_up_i is 0 at the check, at least one reset pulse is issued before done_o reports link_ok_o = 0.
- R4: Each reset pulse on link_rst_o lasts exactly one clock cycle.
- R5: After each reset pulse, and after each failed sample that does not end the attempt, the inputs are next sampled SETTLE_US*TICK_DIV+1 cycles later.
- R6: An attempt that reaches WAITS_PER_TRY failed samples starts a new reset pulse in the cycle after the last of them, as long as fewer than MAX_TRIES pulses have been issued.
- R7: The sample budget WAIT_BUDGET is shared by all attempts of one check and is not reloaded. When it is spent on a failed sample, done_o follows in the next cycle with link_ok_o = 0.
- R8: When an attempt ends after MAX_TRIES pulses have been issued, done_o follows in the next cycle with link_ok_o = 0.
- R9: The first sample that shows both inputs high ends the sequence. done_o follows in the next cycle with link_ok_o = 1, and no further reset pulse is issued.
- R10: A start request made while a check is in progress is ignored: no second done pulse appears and the outcome is unchanged.
- R11: done_o is high for exactly one cycle per check. link_ok_o changes only in the cycle in which done_o is high, and it holds its value afterwards.
- R12: While reset is applied and just after it is released, link_rst_o, done_o and link_ok_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a link check; acted on only when idle |
| link_up_i | input | 1 | Link-up status from the PCS |
| lane_align_i | input | 1 | Lane-alignment status from the PCS |
| link_rst_o | output | 1 | One-cycle link-reset pulse |
| done_o | output | 1 | One-cycle end-of-check pulse |
| link_ok_o | output | 1 | Result of the last check: 1 = link good |

## Verification
A wrong state or a wrong counter in this controller shows up at the ports as a timing error. A mistake in the settle timer or the prescaler moves every later sample, so the cycle of done_o and the count of reset pulses both shift within one settle window. A sample budget that is reloaded per attempt, or a per-attempt counter that is off by one, changes the number of reset pulses and the cycle of done_o. This becomes visible only once the link stays bad long enough for a budget to matter. The bench therefore moves the cycle at which the link turns healthy across every cycle of a full sequence. It does this under each bad-input pattern and for two budget settings, one that ends on the sample budget and one that ends on the attempt budget.

// File: rtl/lrr_pkg.sv
package lrr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PULSE,
        ST_SETTLE,
        ST_SAMPLE,
        ST_DONE
    } lrr_state_t;

endpackage

// File: rtl/lrr_tick_gen.sv
// Microsecond tick prescaler; restarts from zero while clr is high.
module lrr_tick_gen #(
    parameter int TICK_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = !clr && (cnt == LAST);
endmodule

// File: rtl/lrr_settle_timer.sv
// Counts ticks of the settle window; expire is high on the final tick.
module lrr_settle_timer #(
    parameter int SETTLE_US = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expire
);
    localparam int SW = (SETTLE_US > 1) ? $clog2(SETTLE_US) : 1;
    localparam logic [SW-1:0] LAST = SW'(SETTLE_US - 1);

    logic [SW-1:0] ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ticks <= '0;
        else if (clr)
            ticks <= '0;
        else if (tick)
            ticks <= ticks + 1'b1;
    end

    assign expire = tick && (ticks == LAST);
endmodule

// File: rtl/lrr_budget.sv
// Sample budget shared across attempts, per-attempt sample count, attempt count.
module lrr_budget #(
    parameter int WAITS_PER_TRY = 4,
    parameter int MAX_TRIES     = 3,
    parameter int WAIT_BUDGET   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic pulse,
    input  logic sample,
    output logic waits_last,
    output logic try_last,
    output logic tries_last
);
    localparam int WW = $clog2(WAIT_BUDGET + 1);
    localparam int PW = $clog2(WAITS_PER_TRY + 1);
    localparam int TW = $clog2(MAX_TRIES + 1);

    logic [WW-1:0] waits_left;
    logic [PW-1:0] try_cnt;
    logic [TW-1:0] tries;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waits_left <= '0;
            try_cnt    <= '0;
            tries      <= '0;
        end else begin
            if (load)
                waits_left <= WW'(WAIT_BUDGET);
            else if (sample && waits_left != '0)
                waits_left <= waits_left - 1'b1;

            if (pulse)
                try_cnt <= '0;
            else if (sample)
                try_cnt <= try_cnt + 1'b1;

            if (load)
                tries <= '0;
            else if (pulse)
                tries <= tries + 1'b1;
        end
    end

    assign waits_last = (waits_left == WW'(1));
    assign try_last   = (try_cnt == PW'(WAITS_PER_TRY - 1));
    assign tries_last = (tries == TW'(MAX_TRIES));
endmodule

// File: rtl/link_retry_ctrl.sv
module link_retry_ctrl #(
    parameter int TICK_DIV      = 125,
    parameter int SETTLE_US     = 10,
    parameter int WAITS_PER_TRY = 4,
    parameter int MAX_TRIES     = 3,
    parameter int WAIT_BUDGET   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic link_up_i,
    input  logic lane_align_i,
    output logic link_rst_o,
    output logic done_o,
    output logic link_ok_o
);
    import lrr_pkg::*;

    lrr_state_t state, state_nx;
    logic       ok_q, ok_nx;
    logic       healthy;
    logic       tmr_clr, tick, expire;
    logic       waits_last, try_last, tries_last;

    assign healthy = link_up_i && lane_align_i;
    assign tmr_clr = (state != ST_SETTLE);

    lrr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick)
    );

    lrr_settle_timer #(.SETTLE_US(SETTLE_US)) u_settle (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick), .expire(expire)
    );

    lrr_budget #(
        .WAITS_PER_TRY(WAITS_PER_TRY),
        .MAX_TRIES(MAX_TRIES),
        .WAIT_BUDGET(WAIT_BUDGET)
    ) u_budget (
        .clk(clk), .rst_n(rst_n),
        .load(state == ST_CHECK),
        .pulse(state == ST_PULSE),
        .sample(state == ST_SAMPLE),
        .waits_last(waits_last),
        .try_last(try_last),
        .tries_last(tries_last)
    );

    // next state and next result
    always_comb begin
        state_nx = state;
        ok_nx    = ok_q;
        unique case (state)
            ST_IDLE:   if (start_i) state_nx = ST_CHECK;
            ST_CHECK: begin
                if (healthy) begin
                    state_nx = ST_DONE;
                    ok_nx    = 1'b1;
                end else begin
                    state_nx = ST_PULSE;
                end
            end
            ST_PULSE:  state_nx = ST_SETTLE;
            ST_SETTLE: if (expire) state_nx = ST_SAMPLE;
            ST_SAMPLE: begin
                if (healthy) begin
                    state_nx = ST_DONE;
                    ok_nx    = 1'b1;
                end else if (waits_last) begin
                    state_nx = ST_DONE;
                    ok_nx    = 1'b0;
                end else if (try_last) begin
                    if (tries_last) begin
                        state_nx = ST_DONE;
                        ok_nx    = 1'b0;
                    end else begin
                        state_nx = ST_PULSE;
                    end
                end else begin
                    state_nx = ST_SETTLE;
                end
            end
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ok_q  <= 1'b0;
        end else begin
            state <= state_nx;
            ok_q  <= ok_nx;
        end
    end

    // outputs
    always_comb begin
        link_rst_o = (state == ST_PULSE);
        done_o     = (state == ST_DONE);
        link_ok_o  = ok_q;
    end
endmodule

// File: rtl/lrr_checker.sv
module lrr_checker #(
    parameter int MAX_TRIES = 3
) (
    input logic clk,
    input logic rst_n,
    input logic link_rst,
    input logic done,
    input logic link_ok
);
    int unsigned pulses;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pulses <= 0;
        else if (done)
            pulses <= 0;
        else if (link_rst)
            pulses <= pulses + 1;
    end

    a_r4_single_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        link_rst |=> !link_rst);

    a_r11_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(link_ok) |-> done);

    a_r8_attempt_budget: assert property (@(posedge clk) disable iff (!rst_n)
        pulses <= MAX_TRIES);

    a_r3_reset_before_down: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !link_ok) |-> (pulses > 0));

    a_r4_no_pulse_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_rst && done));
endmodule

bind link_retry_ctrl lrr_checker #(.MAX_TRIES(MAX_TRIES)) u_lrr_chk (
    .clk(clk), .rst_n(rst_n), .link_rst(link_rst_o), .done(done_o), .link_ok(link_ok_o)
);

// File: tb/link_retry_ctrl_bench.sv
`timescale 1ns/1ps
module link_retry_ctrl_bench;
    localparam int DIV = 2;
    localparam int SET = 2;
    localparam int PER = 2;
    localparam int MR  = 3;
    localparam int WA  = 5;   // sample budget ends first
    localparam int WB  = 9;   // attempt budget ends first

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_a = 1'b0, start_b = 1'b0;
    logic up_i = 1'b0, al_i = 1'b0;
    logic rst_a, done_a, ok_a, rst_b, done_b, ok_b;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    link_retry_ctrl #(.TICK_DIV(DIV), .SETTLE_US(SET), .WAITS_PER_TRY(PER),
                      .MAX_TRIES(MR), .WAIT_BUDGET(WA)) u_link_retry_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_a), .link_up_i(up_i),
        .lane_align_i(al_i), .link_rst_o(rst_a), .done_o(done_a), .link_ok_o(ok_a));

    link_retry_ctrl #(.TICK_DIV(DIV), .SETTLE_US(SET), .WAITS_PER_TRY(PER),
                      .MAX_TRIES(MR), .WAIT_BUDGET(WB)) u_link_retry_ctrl_b (
        .clk(clk), .rst_n(rst_n), .start_i(start_b), .link_up_i(up_i),
        .lane_align_i(al_i), .link_rst_o(rst_b), .done_o(done_b), .link_ok_o(ok_b));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected outcome computed from the requirements (cycle 0 = check cycle).
    task automatic model(input int sel, input int h, output int dc, output bit up, output int nr);
        int L = SET * DIV;
        int w = (sel == 0) ? WA : WB;
        int r0 = 1;
        int s;
        bit fin = 1'b0;
        up = 1'b0;
        if (h <= 0) begin
            dc = 1; up = 1'b1; nr = 0;
            return;
        end
        nr = 1;
        dc = 0;
        while (!fin) begin
            for (int q = 0; q < PER && !fin; q++) begin
                s = r0 + (q + 1) * (L + 1);
                w--;
                if (h <= s) begin
                    fin = 1'b1; up = 1'b1; dc = s + 1;
                end else if (w == 0) begin
                    fin = 1'b1; up = 1'b0; dc = s + 1;
                end else if (q == PER - 1) begin
                    if (nr == MR) begin
                        fin = 1'b1; up = 1'b0; dc = s + 1;
                    end else begin
                        nr++; r0 = s + 1;
                    end
                end
            end
        end
    endtask

    task automatic set_in(input bit good, input int bad);
        if (good) begin
            up_i = 1'b1; al_i = 1'b1;
        end else begin
            unique case (bad)
                0: begin up_i = 1'b1; al_i = 1'b0; end
                1: begin up_i = 1'b0; al_i = 1'b1; end
                default: begin up_i = 1'b0; al_i = 1'b0; end
            endcase
        end
    endtask

    task automatic run_case(input int sel, input int h, input int bad, input bit poke);
        int edc, eres;
        bit eup;
        int nres = 0, rises = 0, ndone = 0, dcyc = -1;
        bit gotok = 1'b0, prev_rst = 1'b0;
        bit o_rst, o_done, o_ok;
        string tag;
        model(sel, h, edc, eup, eres);
        @(negedge clk);
        if (sel == 0) start_a = 1'b1; else start_b = 1'b1;
        @(negedge clk);
        start_a = 1'b0; start_b = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (i > 0) @(negedge clk);
            set_in(i >= h, bad);
            if (poke && i == 2) begin
                if (sel == 0) start_a = 1'b1; else start_b = 1'b1;
            end else begin
                start_a = 1'b0; start_b = 1'b0;
            end
            o_rst  = (sel == 0) ? rst_a  : rst_b;
            o_done = (sel == 0) ? done_a : done_b;
            o_ok   = (sel == 0) ? ok_a   : ok_b;
            if (o_rst) nres++;
            if (o_rst && !prev_rst) rises++;
            prev_rst = o_rst;
            if (o_done) begin
                ndone++;
                if (dcyc < 0) begin dcyc = i; gotok = o_ok; end
            end
        end
        start_a = 1'b0; start_b = 1'b0;
        o_ok = (sel == 0) ? ok_a : ok_b;
        if (!eup) tag = (sel == 0) ? "R7" : "R8";
        else if (h == 0) tag = "R1";
        else tag = "R9";
        chk(dcyc == edc, {tag, " R5 R6 done cycle"}, dcyc, edc);
        chk(gotok == eup, {tag, " result"}, int'(gotok), int'(eup));
        chk(nres == eres, (bad == 0) ? "R2 reset pulses" : "R3 reset pulses", nres, eres);
        chk(rises == nres, "R4 single-cycle reset pulses", rises, nres);
        chk(ndone == 1, poke ? "R10 busy start ignored" : "R11 one done pulse", ndone, 1);
        chk(o_ok == eup, "R11 result held", int'(o_ok), int'(eup));
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!rst_a && !done_a && !ok_a, "R12 reset outputs A", {rst_a, done_a, ok_a}, 0);
        chk(!rst_b && !done_b && !ok_b, "R12 reset outputs B", {rst_b, done_b, ok_b}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rst_a && !done_a && !ok_a, "R12 after release", {rst_a, done_a, ok_a}, 0);
        for (int sel = 0; sel < 2; sel++)
            for (int bad = 0; bad < 3; bad++) begin
                for (int h = 0; h <= 36; h++)
                    run_case(sel, h, bad, (h > 3) && (h % 2 == 0));
                run_case(sel, 1000, bad, 1'b1);
            end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule